// File: doc/BRIEF.md
# Linear CCD Clock Sequence Generator

This block drives the readout of a two-phase linear CCD. On request it first holds the phase-1 shift clock high and pulses the transfer gate. This moves the photocell charge into the readout register. It then toggles the two complementary shift clocks and produces one output pixel per shift-clock half-period, together with copies of both phases for the last register stage. A reset-gate pulse opens each pixel period. Pulse widths, guard intervals and the pixel period are counts of system-clock ticks. The counts are captured while reset is held, and each is forced into its legal range.

Alongside the clocks the block reports a pixel index and three class flags. A downstream sampler can then tell dark-reference cells, dead cells, image cells and trailing overflow periods apart without keeping a count of its own. A one-cycle strobe marks the first pixel of a line and another marks the end of the line. In continuous mode the next transfer starts at once. In single-shot mode the block waits for a new start request. All outputs leave through one register stage.

Top module: `ccd_line_sequencer`

## Requirements
- R1: While reset is held and after it is released with no start request, the transfer gate, phase 2, reset gate, all class flags, both strobes and the pixel index are 0, and phase 1 is 1.
- R2: During a line, pixel index 1..18 raises only `cell_dark_ref`, 19..20 raises only `cell_dead`, 21..5170 raises only `cell_image`, 5171..5172 raises only `cell_dead`, and 5173..5186 raises no flag. Outside the shifting phase no flag is raised.
- R3: A line has exactly 5186 pixel periods with the index counting 1, 2, … 5186 and reading 0 outside them. `line_done` is high for one cycle, in the cycle right after pixel 5186.
- R4: Each pixel period lasts the clamped pixel count. Phase 1 is low for odd pixel indices and high for even ones.
- R5: Phase 2 is always the complement of phase 1. The last-stage phase-1 and phase-2 outputs always equal phase 1 and phase 2.
- R6: The reset gate is high for the first N cycles of every pixel period and low for the rest. N is the reset count clamped to the range 2 up to (pixel count − 1). The gate is never high outside a pixel period.
- R7: The transfer gate is high for the transfer count clamped to 50..500 cycles, and phase 1 is high throughout.
- R8: The transfer gate rises one guard interval after the line sequence begins. After it falls, phase 1 stays high for exactly guard + resume cycles, and then pixel 1 begins.
- R9: A pixel count below 5 is used as 5. Guard and resume counts below 1 are used as 1.
- R10: `line_start` is high for exactly one cycle, the first cycle of pixel 1.
- R11: In continuous mode the transfer gate rises guard + 1 cycles after `line_done`. In single-shot mode the block goes idle after `line_done`. A start request made while a line is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; timing counts are captured while low |
| start_req | input | 1 | Starts a line when idle |
| run_continuous | input | 1 | 1: back-to-back lines; 0: one line per request |
| cfg_pixel_ticks | input | TICK_W | Pixel period in ticks (min 5) |
| cfg_reset_ticks | input | TICK_W | Reset-gate width in ticks (2 .. pixel−1) |
| cfg_guard_ticks | input | TICK_W | Guard interval around the transfer gate (min 1) |
| cfg_resume_ticks | input | TICK_W | Extra delay before shifting resumes (min 1) |
| cfg_transfer_ticks | input | TG_W | Transfer-gate width in ticks (50..500) |
| xfer_gate | output | 1 | Transfer-gate pulse |
| shift_ph1 | output | 1 | Phase-1 shift clock |
| shift_ph2 | output | 1 | Phase-2 shift clock |
| last_ph1 | output | 1 | Last-stage phase-1 clock |
| last_ph2 | output | 1 | Last-stage phase-2 clock |
| reset_gate | output | 1 | Output-node reset pulse |
| cell_dark_ref | output | 1 | Current pixel is a shielded reference cell |
| cell_dead | output | 1 | Current pixel is a dead cell |
| cell_image | output | 1 | Current pixel is an image cell |
| pixel_index | output | IDX_W | Pixel number 1..5186, 0 when not shifting |
| line_start | output | 1 | First cycle of pixel 1 |
| line_done | output | 1 | Cycle after the last pixel period |

## Verification
Two events can fall in the same cycle. The end of a line and the launch of the next transfer meet when continuous mode is on. A start request can also arrive while a line is still shifting. The bench runs back-to-back lines and measures the number of cycles from `line_done` to the next transfer-gate rise against guard + 1. It also sends a start pulse in the middle of a single-shot line and then confirms that only one transfer pulse appears and that the block is idle afterwards. Pixel boundaries, where the index step, the reset-gate rise and the phase toggle all coincide, are judged on every pixel of every line.

// File: rtl/ccd_seq_pkg.sv
// Shared types and helpers for the linear CCD clock sequencer.
package ccd_seq_pkg;

    // Phases of one line: idle, guard, transfer, guard, resume delay, shifting, end strobe.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PRE    = 3'd1,
        ST_XFER   = 3'd2,
        ST_POST   = 3'd3,
        ST_RESUME = 3'd4,
        ST_SHIFT  = 3'd5,
        ST_DONE   = 3'd6
    } seq_state_e;

    // Class of the pixel currently on the output; at most one bit set.
    typedef struct packed {
        logic dark_ref;
        logic dead;
        logic image;
    } cell_class_t;

    // Clamp a value into [lo, hi]; lo wins when the range is empty.
    function automatic logic [15:0] clamp_u16(input logic [15:0] v,
                                              input logic [15:0] lo,
                                              input logic [15:0] hi);
        logic [15:0] r;
        r = v;
        if (r > hi) r = hi;
        if (r < lo) r = lo;
        return r;
    endfunction

endpackage

// File: rtl/ccd_cfg_latch.sv
// Captures the timing counts while reset is held and forces each into its
// legal range. Assumes the raw inputs are stable during reset.
module ccd_cfg_latch
    import ccd_seq_pkg::*;
#(
    parameter int TICK_W     = 8,
    parameter int TG_W       = 12,
    parameter int PIX_MIN    = 5,
    parameter int RST_MIN    = 2,
    parameter int GUARD_MIN  = 1,
    parameter int RESUME_MIN = 1,
    parameter int XFER_MIN   = 50,
    parameter int XFER_MAX   = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] raw_pix,
    input  logic [TICK_W-1:0] raw_rst,
    input  logic [TICK_W-1:0] raw_guard,
    input  logic [TICK_W-1:0] raw_resume,
    input  logic [TG_W-1:0]   raw_xfer,
    output logic [TICK_W-1:0] pix_len,
    output logic [TICK_W-1:0] rst_len,
    output logic [TICK_W-1:0] guard_len,
    output logic [TICK_W-1:0] resume_len,
    output logic [TG_W-1:0]   xfer_len
);

    localparam logic [15:0] TICK_TOP = 16'((1 << TICK_W) - 1);
    localparam logic [15:0] XFER_TOP = 16'(XFER_MAX);

    logic [TICK_W-1:0] pix_c, rst_c, guard_c, resume_c;
    logic [TG_W-1:0]   xfer_c;

    // Range-limit every count; the reset width is bounded by the pixel period.
    always_comb begin
        pix_c    = TICK_W'(clamp_u16(16'(raw_pix), 16'(PIX_MIN), TICK_TOP));
        rst_c    = TICK_W'(clamp_u16(16'(raw_rst), 16'(RST_MIN), 16'(pix_c) - 16'd1));
        guard_c  = TICK_W'(clamp_u16(16'(raw_guard), 16'(GUARD_MIN), TICK_TOP));
        resume_c = TICK_W'(clamp_u16(16'(raw_resume), 16'(RESUME_MIN), TICK_TOP));
        xfer_c   = TG_W'(clamp_u16(16'(raw_xfer), 16'(XFER_MIN), XFER_TOP));
    end

    // Load while reset is low, hold afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_len    <= pix_c;
            rst_len    <= rst_c;
            guard_len  <= guard_c;
            resume_len <= resume_c;
            xfer_len   <= xfer_c;
        end
    end

endmodule

// File: rtl/ccd_phase_fsm.sv
// Line-level sequencer: idle, guard before the transfer, transfer pulse,
// guard after it, resume delay, pixel shifting, end-of-line strobe.
// Assumes every interval count is at least 1 (guaranteed by ccd_cfg_latch).
module ccd_phase_fsm
    import ccd_seq_pkg::*;
#(
    parameter int TICK_W = 8,
    parameter int TG_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              run_continuous,
    input  logic [TICK_W-1:0] guard_len,
    input  logic [TICK_W-1:0] resume_len,
    input  logic [TG_W-1:0]   xfer_len,
    input  logic              line_last,
    output seq_state_e        state
);

    localparam int CNT_W = (TG_W > TICK_W) ? TG_W : TICK_W;

    seq_state_e       state_n;
    logic [CNT_W-1:0] cnt, cnt_n, span;
    logic             span_end;

    // Length of the interval the current state must last.
    always_comb begin
        case (state)
            ST_PRE, ST_POST: span = CNT_W'(guard_len);
            ST_XFER:         span = CNT_W'(xfer_len);
            ST_RESUME:       span = CNT_W'(resume_len);
            default:         span = CNT_W'(1);
        endcase
        span_end = (cnt == span - 1'b1);
    end

    // Next-state selection.
    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE:   if (start_req) state_n = ST_PRE;
            ST_PRE:    if (span_end)  state_n = ST_XFER;
            ST_XFER:   if (span_end)  state_n = ST_POST;
            ST_POST:   if (span_end)  state_n = ST_RESUME;
            ST_RESUME: if (span_end)  state_n = ST_SHIFT;
            ST_SHIFT:  if (line_last) state_n = ST_DONE;
            ST_DONE:   state_n = run_continuous ? ST_PRE : ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
        if (state_n != state || state == ST_IDLE || state == ST_SHIFT || state == ST_DONE)
            cnt_n = '0;
        else
            cnt_n = cnt + 1'b1;
    end

    // State and interval counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

endmodule

// File: rtl/ccd_pixel_timer.sv
// Pixel-level timing during shifting: tick counter within the pixel period,
// 1-based pixel index, phase-1 level, reset-gate window and line boundaries.
// Assumes pix_len >= 2 and rst_len < pix_len; holds index 1 when not running.
module ccd_pixel_timer #(
    parameter int LINE_PIX = 5186,
    parameter int TICK_W   = 8,
    parameter int IDX_W    = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [TICK_W-1:0] pix_len,
    input  logic [TICK_W-1:0] rst_len,
    output logic [IDX_W-1:0]  index_o,
    output logic              ph1_o,
    output logic              rst_gate_o,
    output logic              first_o,
    output logic              last_o
);

    logic [TICK_W-1:0] tick;
    logic [IDX_W-1:0]  idx;
    logic              tick_end;

    // End of the current pixel period.
    always_comb tick_end = (tick == pix_len - 1'b1);

    // Tick and index counters; restart at pixel 1 whenever shifting stops.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            tick <= '0;
            idx  <= IDX_W'(1);
        end else if (tick_end) begin
            tick <= '0;
            idx  <= idx + 1'b1;
        end else begin
            tick <= tick + 1'b1;
        end
    end

    // Decoded pixel-level outputs.
    always_comb begin
        index_o    = run ? idx : '0;
        ph1_o      = run ? ~idx[0] : 1'b1;
        rst_gate_o = run && (tick < rst_len);
        first_o    = run && (idx == IDX_W'(1)) && (tick == '0);
        last_o     = run && tick_end && (idx == IDX_W'(LINE_PIX));
    end

endmodule

// File: rtl/ccd_cell_classifier.sv
// Maps a pixel index to its cell class in the fixed readout order:
// dark reference, leading dead, image, trailing dead, then overflow.
module ccd_cell_classifier
    import ccd_seq_pkg::*;
#(
    parameter int OB_CELLS    = 18,
    parameter int LEAD_DEAD   = 2,
    parameter int IMAGE_CELLS = 5150,
    parameter int TAIL_DEAD   = 2,
    parameter int IDX_W       = 13
) (
    input  logic             active,
    input  logic [IDX_W-1:0] idx,
    output cell_class_t      cls
);

    localparam logic [IDX_W-1:0] OB_END    = IDX_W'(OB_CELLS);
    localparam logic [IDX_W-1:0] LEAD_END  = IDX_W'(OB_CELLS + LEAD_DEAD);
    localparam logic [IDX_W-1:0] IMAGE_END = IDX_W'(OB_CELLS + LEAD_DEAD + IMAGE_CELLS);
    localparam logic [IDX_W-1:0] TAIL_END  = IDX_W'(OB_CELLS + LEAD_DEAD + IMAGE_CELLS + TAIL_DEAD);

    // Range compare against the region boundaries.
    always_comb begin
        cls          = '0;
        cls.dark_ref = active && (idx != '0) && (idx <= OB_END);
        cls.image    = active && (idx > LEAD_END) && (idx <= IMAGE_END);
        cls.dead     = active && (((idx > OB_END) && (idx <= LEAD_END)) ||
                                  ((idx > IMAGE_END) && (idx <= TAIL_END)));
    end

endmodule

// File: rtl/ccd_line_sequencer.sv
// Top level of the linear CCD clock sequencer. Combines configuration
// capture, line state machine, pixel timer and cell classifier, and
// registers every output once so that the pins are glitch-free.
// Assumes the timing inputs are stable while rst_n is low.
module ccd_line_sequencer
    import ccd_seq_pkg::*;
#(
    parameter int LINE_PIX    = 5186,
    parameter int OB_CELLS    = 18,
    parameter int LEAD_DEAD   = 2,
    parameter int IMAGE_CELLS = 5150,
    parameter int TAIL_DEAD   = 2,
    parameter int TICK_W      = 8,
    parameter int TG_W        = 12,
    parameter int PIX_MIN     = 5,
    parameter int RST_MIN     = 2,
    parameter int GUARD_MIN   = 1,
    parameter int RESUME_MIN  = 1,
    parameter int XFER_MIN    = 50,
    parameter int XFER_MAX    = 500,
    localparam int IDX_W      = $clog2(LINE_PIX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              run_continuous,
    input  logic [TICK_W-1:0] cfg_pixel_ticks,
    input  logic [TICK_W-1:0] cfg_reset_ticks,
    input  logic [TICK_W-1:0] cfg_guard_ticks,
    input  logic [TICK_W-1:0] cfg_resume_ticks,
    input  logic [TG_W-1:0]   cfg_transfer_ticks,
    output logic              xfer_gate,
    output logic              shift_ph1,
    output logic              shift_ph2,
    output logic              last_ph1,
    output logic              last_ph2,
    output logic              reset_gate,
    output logic              cell_dark_ref,
    output logic              cell_dead,
    output logic              cell_image,
    output logic [IDX_W-1:0]  pixel_index,
    output logic              line_start,
    output logic              line_done
);

    logic [TICK_W-1:0] pix_len, rst_len, guard_len, resume_len;
    logic [TG_W-1:0]   xfer_len;
    seq_state_e        state;
    logic              shifting, line_last;
    logic [IDX_W-1:0]  idx_w;
    logic              ph1_w, rgate_w, first_w;
    cell_class_t       cls_w;

    ccd_cfg_latch #(
        .TICK_W(TICK_W), .TG_W(TG_W), .PIX_MIN(PIX_MIN), .RST_MIN(RST_MIN),
        .GUARD_MIN(GUARD_MIN), .RESUME_MIN(RESUME_MIN),
        .XFER_MIN(XFER_MIN), .XFER_MAX(XFER_MAX)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .raw_pix(cfg_pixel_ticks), .raw_rst(cfg_reset_ticks),
        .raw_guard(cfg_guard_ticks), .raw_resume(cfg_resume_ticks),
        .raw_xfer(cfg_transfer_ticks),
        .pix_len(pix_len), .rst_len(rst_len), .guard_len(guard_len),
        .resume_len(resume_len), .xfer_len(xfer_len)
    );

    ccd_phase_fsm #(.TICK_W(TICK_W), .TG_W(TG_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req),
        .run_continuous(run_continuous), .guard_len(guard_len),
        .resume_len(resume_len), .xfer_len(xfer_len),
        .line_last(line_last), .state(state)
    );

    // Shifting runs only in the pixel phase of the line.
    always_comb shifting = (state == ST_SHIFT);

    ccd_pixel_timer #(.LINE_PIX(LINE_PIX), .TICK_W(TICK_W), .IDX_W(IDX_W)) u_pix (
        .clk(clk), .rst_n(rst_n), .run(shifting), .pix_len(pix_len),
        .rst_len(rst_len), .index_o(idx_w), .ph1_o(ph1_w),
        .rst_gate_o(rgate_w), .first_o(first_w), .last_o(line_last)
    );

    ccd_cell_classifier #(
        .OB_CELLS(OB_CELLS), .LEAD_DEAD(LEAD_DEAD), .IMAGE_CELLS(IMAGE_CELLS),
        .TAIL_DEAD(TAIL_DEAD), .IDX_W(IDX_W)
    ) u_cls (
        .active(shifting), .idx(idx_w), .cls(cls_w)
    );

    // Output register stage; phase 2 and last-stage copies derive from phase 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_gate     <= 1'b0;
            shift_ph1     <= 1'b1;
            shift_ph2     <= 1'b0;
            last_ph1      <= 1'b1;
            last_ph2      <= 1'b0;
            reset_gate    <= 1'b0;
            cell_dark_ref <= 1'b0;
            cell_dead     <= 1'b0;
            cell_image    <= 1'b0;
            pixel_index   <= '0;
            line_start    <= 1'b0;
            line_done     <= 1'b0;
        end else begin
            xfer_gate     <= (state == ST_XFER);
            shift_ph1     <= ph1_w;
            shift_ph2     <= ~ph1_w;
            last_ph1      <= ph1_w;
            last_ph2      <= ~ph1_w;
            reset_gate    <= rgate_w;
            cell_dark_ref <= cls_w.dark_ref;
            cell_dead     <= cls_w.dead;
            cell_image    <= cls_w.image;
            pixel_index   <= idx_w;
            line_start    <= first_w;
            line_done     <= (state == ST_DONE);
        end
    end

endmodule

// File: rtl/ccd_line_sequencer_chk.sv
// Property checker for ccd_line_sequencer, attached through bind below.
module ccd_line_sequencer_chk #(
    parameter int LINE_PIX = 5186,
    parameter int IDX_W    = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_gate,
    input logic             shift_ph1,
    input logic             shift_ph2,
    input logic             last_ph1,
    input logic             last_ph2,
    input logic             reset_gate,
    input logic             cell_dark_ref,
    input logic             cell_dead,
    input logic             cell_image,
    input logic [IDX_W-1:0] pixel_index,
    input logic             line_start,
    input logic             line_done
);

    // R5: complementary phases and last-stage copies.
    p_phase_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_ph2 == !shift_ph1) && (last_ph1 == shift_ph1) && (last_ph2 == shift_ph2));

    // R7: phase 1 held high during the transfer pulse.
    p_xfer_ph1_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_gate |-> shift_ph1);

    // R6: reset gate only inside a pixel period.
    p_rgate_in_pixel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_gate |-> (pixel_index != '0));

    // R2: at most one class flag, none outside shifting.
    p_class_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cell_dark_ref, cell_dead, cell_image}) &&
        ((pixel_index == '0) -> !(cell_dark_ref || cell_dead || cell_image)));

    // R10: line start lasts a single cycle and sits on pixel 1.
    p_start_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> (pixel_index == IDX_W'(1)) ##1 !line_start);

    // R3: end strobe follows the last pixel.
    p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_done) |-> ($past(pixel_index) == IDX_W'(LINE_PIX)) && (pixel_index == '0));

    // R3: index holds or steps by one while shifting.
    p_index_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pixel_index != '0) && ($past(pixel_index) != '0)) |->
        ((pixel_index == $past(pixel_index)) || (pixel_index == $past(pixel_index) + 1'b1)));

    // R4: phase 1 low on odd pixels, high on even pixels.
    p_ph1_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pixel_index != '0) |-> (shift_ph1 == !pixel_index[0]));

endmodule

bind ccd_line_sequencer ccd_line_sequencer_chk #(.LINE_PIX(LINE_PIX), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_gate(xfer_gate), .shift_ph1(shift_ph1),
    .shift_ph2(shift_ph2), .last_ph1(last_ph1), .last_ph2(last_ph2),
    .reset_gate(reset_gate), .cell_dark_ref(cell_dark_ref), .cell_dead(cell_dead),
    .cell_image(cell_image), .pixel_index(pixel_index), .line_start(line_start),
    .line_done(line_done)
);

// File: tb/sim_ccd_line_sequencer.sv
module sim_ccd_line_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int LINE_PIX   = 5186;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0;
    logic        run_continuous = 1'b0;
    logic [7:0]  cfg_pixel_ticks = 8'd5, cfg_reset_ticks = 8'd2;
    logic [7:0]  cfg_guard_ticks = 8'd5, cfg_resume_ticks = 8'd10;
    logic [11:0] cfg_transfer_ticks = 12'd100;
    logic        xfer_gate, shift_ph1, shift_ph2, last_ph1, last_ph2, reset_gate;
    logic        cell_dark_ref, cell_dead, cell_image, line_start, line_done;
    logic [12:0] pixel_index;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccd_line_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .run_continuous(run_continuous),
        .cfg_pixel_ticks(cfg_pixel_ticks), .cfg_reset_ticks(cfg_reset_ticks),
        .cfg_guard_ticks(cfg_guard_ticks), .cfg_resume_ticks(cfg_resume_ticks),
        .cfg_transfer_ticks(cfg_transfer_ticks),
        .xfer_gate(xfer_gate), .shift_ph1(shift_ph1), .shift_ph2(shift_ph2),
        .last_ph1(last_ph1), .last_ph2(last_ph2), .reset_gate(reset_gate),
        .cell_dark_ref(cell_dark_ref), .cell_dead(cell_dead), .cell_image(cell_image),
        .pixel_index(pixel_index), .line_start(line_start), .line_done(line_done)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 0;
    int exp_pix, exp_rst, exp_xfer, exp_guard, exp_res;

    // Monitor state.
    bit mon_on = 0;
    int prev_idx, prev_xfer, idx_len, rst_len, xfer_len;
    int gap, gap_on, done_gap, done_gap_on, xfer_rises, lines, starts;
    int ob_c, dead_c, img_c, e_flags, e_phase, e_par, e_len, e_rst, e_seq, e_start, e_done, e_xph1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clampv(input int v, input int lo, input int hi);
        int r;
        r = v;
        if (r > hi) r = hi;
        if (r < lo) r = lo;
        return r;
    endfunction

    // Class from the requirement: 1 dark ref, 2 dead, 3 image, 0 none.
    function automatic int exp_class(input int i);
        if (i >= 1 && i <= 18) return 1;
        if (i >= 19 && i <= 20) return 2;
        if (i >= 21 && i <= 5170) return 3;
        if (i >= 5171 && i <= 5172) return 2;
        return 0;
    endfunction

    task automatic clear_mon();
        prev_idx = 0; prev_xfer = 0; idx_len = 0; rst_len = 0; xfer_len = 0;
        gap = 0; gap_on = 0; done_gap = 0; done_gap_on = 0; xfer_rises = 0;
        lines = 0; starts = 0; ob_c = 0; dead_c = 0; img_c = 0;
        e_flags = 0; e_phase = 0; e_par = 0; e_len = 0; e_rst = 0; e_seq = 0;
        e_start = 0; e_done = 0; e_xph1 = 0;
    endtask

    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            int got, ic;
            if (shift_ph2 != !shift_ph1 || last_ph1 != shift_ph1 || last_ph2 != shift_ph2) e_phase++;
            if (xfer_gate) begin
                xfer_len++;
                if (!shift_ph1) e_xph1++;
            end
            if (done_gap_on) done_gap++;
            if (xfer_gate && !prev_xfer) begin
                xfer_rises++;
                if (done_gap_on) check(done_gap == exp_guard + 1, "R11 continuous relaunch gap", done_gap, exp_guard + 1);
                done_gap_on = 0;
            end
            if (!xfer_gate && prev_xfer) begin
                check(xfer_len == exp_xfer, "R7 transfer width", xfer_len, exp_xfer);
                check(e_xph1 == 0, "R7 phase1 high during transfer", e_xph1, 0);
                xfer_len = 0; e_xph1 = 0; gap_on = 1; gap = 0;
            end
            if (gap_on) begin
                if (shift_ph1 && pixel_index == 0) gap++;
                else if (!shift_ph1) begin
                    check(gap == exp_guard + exp_res, "R8 guard+resume before pixel 1", gap, exp_guard + exp_res);
                    gap_on = 0;
                end
            end
            if (int'(pixel_index) != prev_idx) begin
                if (prev_idx != 0) begin
                    if (idx_len != exp_pix) e_len++;
                    if (rst_len != exp_rst) e_rst++;
                end
                if (pixel_index != 0 && int'(pixel_index) != prev_idx + 1) e_seq++;
                if (pixel_index != 0 && !reset_gate) e_rst++;
                idx_len = 0; rst_len = 0;
            end
            if (pixel_index != 0) begin
                idx_len++;
                if (reset_gate) rst_len++;
                if (shift_ph1 != !pixel_index[0]) e_par++;
            end else if (reset_gate) e_rst++;
            got = cell_dark_ref ? 1 : cell_dead ? 2 : cell_image ? 3 : 0;
            ic  = (pixel_index == 0) ? 0 : exp_class(int'(pixel_index));
            if (got != ic || (int'(cell_dark_ref) + int'(cell_dead) + int'(cell_image)) > 1) e_flags++;
            if (cell_dark_ref) ob_c++;
            if (cell_dead) dead_c++;
            if (cell_image) img_c++;
            if (line_start) starts++;
            if (line_start != (pixel_index == 1 && prev_idx == 0)) e_start++;
            if (line_done != (pixel_index == 0 && prev_idx == LINE_PIX)) e_done++;
            if (line_done) begin
                lines++;
                check(ob_c == 18 * exp_pix, "R2 dark-ref cycles", ob_c, 18 * exp_pix);
                check(dead_c == 4 * exp_pix, "R2 dead cycles", dead_c, 4 * exp_pix);
                check(img_c == 5150 * exp_pix, "R2 image cycles", img_c, 5150 * exp_pix);
                check(e_flags == 0, "R2 class by index", e_flags, 0);
                check(e_seq == 0 && e_done == 0, "R3 index sequence and end strobe", e_seq + e_done, 0);
                check(e_len == 0 && e_par == 0, "R4 pixel length and phase parity", e_len + e_par, 0);
                check(e_phase == 0, "R5 phase pairs", e_phase, 0);
                check(e_rst == 0, "R6 reset gate window", e_rst, 0);
                check(starts == 1 && e_start == 0, "R10 line start strobe", starts, 1);
                ob_c = 0; dead_c = 0; img_c = 0; e_flags = 0; e_seq = 0; e_done = 0;
                e_len = 0; e_par = 0; e_phase = 0; e_rst = 0; starts = 0; e_start = 0;
                done_gap_on = 1; done_gap = 0;
            end
            prev_idx  = int'(pixel_index);
            prev_xfer = int'(xfer_gate);
        end
    end

    task automatic configure(input int pix, input int rst, input int xfer,
                             input int guard, input int res, input bit cont);
        mon_on = 0;
        @(negedge clk);
        rst_n = 1'b0;
        cfg_pixel_ticks = 8'(pix); cfg_reset_ticks = 8'(rst);
        cfg_guard_ticks = 8'(guard); cfg_resume_ticks = 8'(res);
        cfg_transfer_ticks = 12'(xfer); run_continuous = cont;
        exp_pix   = clampv(pix, 5, 255);
        exp_rst   = clampv(rst, 2, exp_pix - 1);
        exp_xfer  = clampv(xfer, 50, 500);
        exp_guard = clampv(guard, 1, 255);
        exp_res   = clampv(res, 1, 255);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        clear_mon();
        @(negedge clk);
        mon_on = 1;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
    endtask

    task automatic wait_lines(input int n);
        while (lines < n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1737));
        // Scenario A: random legal timing, single shot, stray start mid-line.
        configure(5 + int'($urandom % 2), 2 + int'($urandom % 3), 50 + int'($urandom % 100),
                  1 + int'($urandom % 8), 1 + int'($urandom % 10), 1'b0);
        @(negedge clk);
        check(!xfer_gate && shift_ph1 && !shift_ph2 && !reset_gate && pixel_index == 0 &&
              !cell_dark_ref && !cell_dead && !cell_image && !line_start && !line_done,
              "R1 idle state after reset", int'(pixel_index), 0);
        check(shift_ph1 == 1'b1, "R1 phase1 idles high", int'(shift_ph1), 1);
        pulse_start();
        repeat (3000) @(negedge clk);
        pulse_start();
        wait_lines(1);
        repeat (700) @(negedge clk);
        check(xfer_rises == 1, "R11 start while busy ignored", xfer_rises, 1);
        check(pixel_index == 0 && shift_ph1 && !xfer_gate, "R11 single shot returns idle", int'(pixel_index), 0);

        // Scenario B: all counts below minimum, continuous for two lines.
        configure(1, 0, 10, 0, 0, 1'b1);
        check(exp_pix == 5 && exp_guard == 1 && exp_res == 1, "R9 clamp expectations", exp_pix, 5);
        pulse_start();
        while (!(lines == 1 && starts == 1)) @(negedge clk);
        run_continuous = 1'b0;
        wait_lines(2);
        check(xfer_rises == 2, "R11 continuous back-to-back count", xfer_rises, 2);
        repeat (300) @(negedge clk);
        check(xfer_rises == 2 && pixel_index == 0, "R11 idle after mode cleared", xfer_rises, 2);

        // Scenario C: counts above maximum.
        configure(6, 200, 4000, 3, 7, 1'b0);
        pulse_start();
        wait_lines(1);
        check(lines == 1, "R3 one line completed", lines, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule